// File: doc/BRIEF.md
# Deferred-completion bus target with single retry slot

This block is the target side of a shared, multi-drop parallel bus. An initiator opens a transaction with an address phase and then presents one data phase. The target does not hold the bus with wait states while its slow internal resource works. It records the request, ends the transaction with a retry (STOP instead of TRDY), and runs the access through a ready/valid backend port in the background. The initiator is expected to reissue exactly the same request later. When that repeat arrives and the backend result is ready, the target finishes it normally with TRDY and, for reads, drives the stored data.

There is one recording slot. Any other request that arrives while the slot is occupied is retried and is not recorded. Matching uses only the transaction fields (command, address, byte enables, and write data for writes). It does not depend on which initiator asked, so any master that presents an identical request receives the result. The slot is released after one delivery, or when a completed result has waited 2^DISCARD_W clocks without a matching repeat.

Bus-side states: BUS_IDLE (waits for a new address phase), BUS_CLAIM (DEVSEL asserted, waits for IRDY and decides), BUS_RESP (one cycle of TRDY or STOP). Transitions: BUS_IDLE→BUS_CLAIM on an address phase that hits the window with a supported command; BUS_CLAIM→BUS_RESP when IRDY is sampled; BUS_RESP→BUS_IDLE always. Slot states: SLOT_EMPTY, SLOT_ISSUE (backend request valid), SLOT_WAIT (request accepted, waiting for the response), SLOT_DONE (result held). Transitions: SLOT_EMPTY→SLOT_ISSUE on a recorded request; SLOT_ISSUE→SLOT_WAIT on req_ready; SLOT_WAIT→SLOT_DONE on resp_valid; SLOT_DONE→SLOT_EMPTY on delivery or on discard-timer expiry.

Top module: `dt_target`

## Requirements
- R1: After reset, devsel_o, trdy_o, stop_o, ad_oe_o and req_valid_o are all low.
- R2: The target does not claim an address phase whose address lies outside the window (upper bits above WIN_BITS differ from BASE_ADDR), or whose command is not one of I/O read 4'b0010, memory read 4'b0110 or I/O write 4'b0011. For such a phase devsel_o, trdy_o and stop_o stay low.
- R3: For a claimed address phase, devsel_o is high in the cycle after the address edge, without TRDY or STOP.
- R4: The data edge (IRDY sampled) of a claimed request that finds the slot empty produces STOP with TRDY low in the next cycle. Exactly one backend request then carries the command's write flag (set for 4'b0011), the address, the data-phase byte enables and, for writes, the data-phase AD value.
- R5: While the slot is occupied, a non-matching claimed request gets STOP and starts no backend request, and the stored request is still delivered later.
- R6: A matching repeat that arrives before the backend has answered gets STOP.
- R7: A matching repeat after the backend has answered gets TRDY (STOP low), and for reads it drives ad_oe_o high with ad_o equal to the backend read data, for exactly one cycle.
- R8: A match requires identical byte enables, and for writes identical data. A repeat that differs in either is retried and is not delivered.
- R9: After one delivery the slot is free, so an identical request is recorded anew (STOP plus a new backend request).
- R10: A completed result with no matching repeat for 2^DISCARD_W clocks is discarded, so the next identical request is recorded anew.
- R11: trdy_o and stop_o are never high together, and either one implies devsel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Transaction frame, active high; its rising edge marks the address phase |
| irdy_i | input | 1 | Initiator ready for the data phase |
| ad_i | input | AW | Address in the address phase, write data in the data phase |
| cbe_i | input | 4 | Command in the address phase, byte enables (active high) in the data phase |
| devsel_o | output | 1 | Target claims the transaction |
| trdy_o | output | 1 | Target completes the data phase |
| stop_o | output | 1 | Target requests retry |
| ad_o | output | DW | Read data driven with trdy_o |
| ad_oe_o | output | 1 | ad_o is valid and should be driven |
| req_valid_o | output | 1 | Backend request valid |
| req_ready_i | input | 1 | Backend accepts the request |
| req_write_o | output | 1 | Backend request is a write |
| req_addr_o | output | AW | Backend request address |
| req_be_o | output | DW/8 | Backend request byte enables |
| req_wdata_o | output | DW | Backend request write data |
| resp_valid_i | input | 1 | Backend response valid (one cycle) |
| resp_rdata_i | input | DW | Backend read data |

## Verification
DEVSEL is due one clock after the address edge. TRDY or STOP is due one clock after the edge that samples IRDY, so the bench samples the claim on the falling edge after the address edge and the response on the falling edge after the data edge. A recorded request appears on the backend port in the cycle after the data edge. Its handshake is counted by the bench's backend model, which answers three clocks after acceptance. The bench therefore waits at least ten clocks before a repeat that expects data, and sends a repeat at once when it expects an early retry. The discard window is checked by idling for 2^DISCARD_W plus a margin of clocks and then confirming that the request is recorded again.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_CLAIM = 2'd1,
        BUS_RESP  = 2'd2
    } bus_state_t;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_ISSUE = 2'd1,
        SLOT_WAIT  = 2'd2,
        SLOT_DONE  = 2'd3
    } slot_state_t;

    function automatic logic cmd_supported(input logic [3:0] c);
        return (c == CMD_IO_RD) || (c == CMD_IO_WR) || (c == CMD_MEM_RD);
    endfunction

    function automatic logic cmd_is_write(input logic [3:0] c);
        return c == CMD_IO_WR;
    endfunction

endpackage

// File: rtl/dt_match.sv
module dt_match #(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int BW = DW / 8
) (
    input  logic [3:0]    cand_cmd,
    input  logic [AW-1:0] cand_addr,
    input  logic [BW-1:0] cand_be,
    input  logic [DW-1:0] cand_data,
    input  logic [3:0]    held_cmd,
    input  logic [AW-1:0] held_addr,
    input  logic [BW-1:0] held_be,
    input  logic [DW-1:0] held_data,
    output logic          same
);
    import dt_pkg::*;

    logic data_ok;

    always_comb begin
        data_ok = !cmd_is_write(held_cmd) || (cand_data == held_data);
        same    = (cand_cmd == held_cmd) && (cand_addr == held_addr) &&
                  (cand_be == held_be) && data_ok;
    end

endmodule

// File: rtl/dt_slot.sv
module dt_slot #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int DISCARD_W = 15,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_fire,
    input  logic [3:0]    rec_cmd,
    input  logic [AW-1:0] rec_addr,
    input  logic [BW-1:0] rec_be,
    input  logic [DW-1:0] rec_data,
    input  logic          dlv_fire,
    output logic          busy,
    output logic          done,
    output logic [3:0]    held_cmd,
    output logic [AW-1:0] held_addr,
    output logic [BW-1:0] held_be,
    output logic [DW-1:0] held_data,
    output logic [DW-1:0] held_rdata,
    output logic          req_valid,
    input  logic          req_ready,
    output logic          req_write,
    output logic [AW-1:0] req_addr,
    output logic [BW-1:0] req_be,
    output logic [DW-1:0] req_wdata,
    input  logic          resp_valid,
    input  logic [DW-1:0] resp_rdata
);
    import dt_pkg::*;

    slot_state_t          st, st_nx;
    logic [DISCARD_W-1:0] age;
    logic                 expire;

    assign expire = (age == {DISCARD_W{1'b1}});

    always_comb begin
        st_nx = st;
        unique case (st)
            SLOT_EMPTY: if (rec_fire)   st_nx = SLOT_ISSUE;
            SLOT_ISSUE: if (req_ready)  st_nx = SLOT_WAIT;
            SLOT_WAIT:  if (resp_valid) st_nx = SLOT_DONE;
            SLOT_DONE:  if (dlv_fire || expire) st_nx = SLOT_EMPTY;
            default:    st_nx = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= SLOT_EMPTY;
            age        <= '0;
            held_cmd   <= '0;
            held_addr  <= '0;
            held_be    <= '0;
            held_data  <= '0;
            held_rdata <= '0;
        end else begin
            st <= st_nx;
            if (st == SLOT_EMPTY && rec_fire) begin
                held_cmd  <= rec_cmd;
                held_addr <= rec_addr;
                held_be   <= rec_be;
                held_data <= rec_data;
            end
            if (st == SLOT_WAIT && resp_valid) begin
                held_rdata <= resp_rdata;
                age        <= '0;
            end else if (st == SLOT_DONE) begin
                age <= age + 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (st != SLOT_EMPTY);
        done      = (st == SLOT_DONE);
        req_valid = (st == SLOT_ISSUE);
        req_write = cmd_is_write(held_cmd);
        req_addr  = held_addr;
        req_be    = held_be;
        req_wdata = held_data;
    end

endmodule

// File: rtl/dt_bus_fsm.sv
module dt_bus_fsm #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int WIN_BITS = 12,
    parameter logic [AW-1:0] BASE_ADDR = 32'h4000_0000,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    input  logic          irdy_i,
    input  logic [AW-1:0] ad_i,
    input  logic [3:0]    cbe_i,
    input  logic          slot_busy,
    input  logic          slot_done,
    input  logic          slot_same,
    input  logic [DW-1:0] slot_rdata,
    output logic [3:0]    cur_cmd,
    output logic [AW-1:0] cur_addr,
    output logic          rec_fire,
    output logic          dlv_fire,
    output logic          devsel_o,
    output logic          trdy_o,
    output logic          stop_o,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o
);
    import dt_pkg::*;

    bus_state_t    st, st_nx;
    logic          frame_q;
    logic          resp_data;
    logic [DW-1:0] ad_q;
    logic          start, in_win, decide;

    always_comb begin
        start    = frame_i && !frame_q;
        in_win   = (ad_i[AW-1:WIN_BITS] == BASE_ADDR[AW-1:WIN_BITS]);
        decide   = (st == BUS_CLAIM) && irdy_i;
        rec_fire = decide && !slot_busy;
        dlv_fire = decide && slot_busy && slot_done && slot_same;
        st_nx    = st;
        unique case (st)
            BUS_IDLE:  if (start && in_win && cmd_supported(cbe_i)) st_nx = BUS_CLAIM;
            BUS_CLAIM: if (irdy_i) st_nx = BUS_RESP;
            BUS_RESP:  st_nx = BUS_IDLE;
            default:   st_nx = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= BUS_IDLE;
            frame_q   <= 1'b0;
            cur_cmd   <= '0;
            cur_addr  <= '0;
            resp_data <= 1'b0;
            ad_q      <= '0;
        end else begin
            st      <= st_nx;
            frame_q <= frame_i;
            if (st == BUS_IDLE && start) begin
                cur_cmd  <= cbe_i;
                cur_addr <= ad_i;
            end
            if (decide) begin
                resp_data <= dlv_fire;
                if (dlv_fire) ad_q <= slot_rdata;
            end
        end
    end

    always_comb begin
        devsel_o = (st == BUS_CLAIM) || (st == BUS_RESP);
        trdy_o   = (st == BUS_RESP) && resp_data;
        stop_o   = (st == BUS_RESP) && !resp_data;
        ad_oe_o  = trdy_o && !cmd_is_write(cur_cmd);
        ad_o     = ad_q;
    end

endmodule

// File: rtl/dt_target.sv
module dt_target #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int WIN_BITS = 12,
    parameter logic [AW-1:0] BASE_ADDR = 32'h4000_0000,
    parameter int DISCARD_W = 15,
    localparam int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    input  logic          irdy_i,
    input  logic [AW-1:0] ad_i,
    input  logic [3:0]    cbe_i,
    output logic          devsel_o,
    output logic          trdy_o,
    output logic          stop_o,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o,
    output logic          req_valid_o,
    input  logic          req_ready_i,
    output logic          req_write_o,
    output logic [AW-1:0] req_addr_o,
    output logic [BW-1:0] req_be_o,
    output logic [DW-1:0] req_wdata_o,
    input  logic          resp_valid_i,
    input  logic [DW-1:0] resp_rdata_i
);

    logic [3:0]    cur_cmd, held_cmd;
    logic [AW-1:0] cur_addr, held_addr;
    logic [BW-1:0] held_be;
    logic [DW-1:0] held_data, held_rdata;
    logic          rec_fire, dlv_fire, slot_busy, slot_done, slot_same;

    dt_bus_fsm #(.AW(AW), .DW(DW), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)) u_bus (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .irdy_i(irdy_i),
        .ad_i(ad_i), .cbe_i(cbe_i),
        .slot_busy(slot_busy), .slot_done(slot_done), .slot_same(slot_same),
        .slot_rdata(held_rdata), .cur_cmd(cur_cmd), .cur_addr(cur_addr),
        .rec_fire(rec_fire), .dlv_fire(dlv_fire),
        .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o),
        .ad_o(ad_o), .ad_oe_o(ad_oe_o)
    );

    dt_match #(.AW(AW), .DW(DW)) u_match (
        .cand_cmd(cur_cmd), .cand_addr(cur_addr),
        .cand_be(cbe_i[BW-1:0]), .cand_data(ad_i[DW-1:0]),
        .held_cmd(held_cmd), .held_addr(held_addr),
        .held_be(held_be), .held_data(held_data),
        .same(slot_same)
    );

    dt_slot #(.AW(AW), .DW(DW), .DISCARD_W(DISCARD_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .rec_fire(rec_fire), .rec_cmd(cur_cmd), .rec_addr(cur_addr),
        .rec_be(cbe_i[BW-1:0]), .rec_data(ad_i[DW-1:0]),
        .dlv_fire(dlv_fire), .busy(slot_busy), .done(slot_done),
        .held_cmd(held_cmd), .held_addr(held_addr), .held_be(held_be),
        .held_data(held_data), .held_rdata(held_rdata),
        .req_valid(req_valid_o), .req_ready(req_ready_i),
        .req_write(req_write_o), .req_addr(req_addr_o),
        .req_be(req_be_o), .req_wdata(req_wdata_o),
        .resp_valid(resp_valid_i), .resp_rdata(resp_rdata_i)
    );

endmodule

// File: rtl/dt_target_chk.sv
module dt_target_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          devsel_o,
    input logic          trdy_o,
    input logic          stop_o,
    input logic          req_valid_o,
    input logic          req_ready_i,
    input logic [AW-1:0] req_addr_o,
    input logic [DW-1:0] req_wdata_o
);

    // R11
    stop_trdy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(trdy_o && stop_o));

    // R11
    resp_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_o || stop_o) |-> devsel_o);

    // R3
    claim_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_o) |-> (!trdy_o && !stop_o));

    // R7
    resp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trdy_o |=> (!trdy_o && !stop_o));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=>
            (req_valid_o && $stable(req_addr_o) && $stable(req_wdata_o)));

endmodule

bind dt_target dt_target_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .devsel_o(devsel_o), .trdy_o(trdy_o),
    .stop_o(stop_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o)
);

// File: tb/sim_dt_target.sv
module sim_dt_target;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DISCARD_W = 15;
    localparam logic [31:0] KEY = 32'h5A5A_5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_i = 1'b0, irdy_i = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        devsel_o, trdy_o, stop_o, ad_oe_o;
    logic [31:0] ad_o;
    logic        req_valid_o, req_write_o;
    logic        req_ready_i = 1'b1;
    logic [31:0] req_addr_o, req_wdata_o;
    logic [3:0]  req_be_o;
    logic        resp_valid_i;
    logic [31:0] resp_rdata_i;

    int n_chk = 0, n_bad = 0;
    int n_req;
    logic [31:0] last_addr, last_wdata, stash;
    logic [3:0]  last_be;
    logic        last_wr;
    int lat;

    logic s_sel, s_trdy, s_stop, s_oe;
    logic [31:0] s_ad;

    always #2.5 clk = ~clk;

    dt_target #(.DISCARD_W(DISCARD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .irdy_i(irdy_i),
        .ad_i(ad_i), .cbe_i(cbe_i), .devsel_o(devsel_o), .trdy_o(trdy_o),
        .stop_o(stop_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_write_o(req_write_o), .req_addr_o(req_addr_o),
        .req_be_o(req_be_o), .req_wdata_o(req_wdata_o),
        .resp_valid_i(resp_valid_i), .resp_rdata_i(resp_rdata_i)
    );

    // backend model: answers three clocks after acceptance
    always @(posedge clk) begin
        if (!rst_n) begin
            n_req <= 0; lat <= 0; resp_valid_i <= 1'b0; resp_rdata_i <= '0;
            stash <= '0; last_addr <= '0; last_wdata <= '0; last_be <= '0; last_wr <= 1'b0;
        end else begin
            resp_valid_i <= 1'b0;
            if (lat != 0) begin
                lat <= lat - 1;
                if (lat == 1) begin
                    resp_valid_i <= 1'b1;
                    resp_rdata_i <= stash ^ KEY;
                end
            end
            if (req_valid_o && req_ready_i) begin
                lat <= 3; stash <= req_addr_o; n_req <= n_req + 1;
                last_addr <= req_addr_o; last_wdata <= req_wdata_o;
                last_be <= req_be_o; last_wr <= req_write_o;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic txn(input logic [3:0] cmd, input logic [31:0] addr,
                       input logic [3:0] be, input logic [31:0] data);
        @(negedge clk);
        frame_i = 1'b1; ad_i = addr; cbe_i = cmd; irdy_i = 1'b0;
        @(negedge clk);
        s_sel = devsel_o;
        frame_i = 1'b0; irdy_i = 1'b1; ad_i = data; cbe_i = be;
        @(negedge clk);
        s_trdy = trdy_o; s_stop = stop_o; s_oe = ad_oe_o; s_ad = ad_o;
        irdy_i = 1'b0; ad_i = '0; cbe_i = '0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 devsel", {31'd0, devsel_o}, 32'd0);
        check("R1 trdy/stop/oe", {29'd0, trdy_o, stop_o, ad_oe_o}, 32'd0);
        check("R1 req_valid", {31'd0, req_valid_o}, 32'd0);
    endtask

    task automatic t_miss;
        int n0 = n_req;
        txn(4'b0110, 32'h5000_0010, 4'hF, '0);
        check("R2 out of window sel", {29'd0, s_sel, s_trdy, s_stop}, 32'd0);
        txn(4'b0111, 32'h4000_0010, 4'hF, 32'h1);
        check("R2 bad cmd sel", {29'd0, s_sel, s_trdy, s_stop}, 32'd0);
        idle(6);
        check("R2 no backend", n_req, n0);
    endtask

    task automatic t_basic_read;
        int n0 = n_req;
        txn(4'b0110, 32'h4000_0100, 4'hF, '0);
        check("R3 devsel after address", {31'd0, s_sel}, 32'd1);
        check("R4 first gets stop", {30'd0, s_trdy, s_stop}, 32'd1);
        txn(4'b0110, 32'h4000_0100, 4'hF, '0);
        check("R6 early repeat retried", {30'd0, s_trdy, s_stop}, 32'd1);
        check("R4 one backend req", n_req, n0 + 1);
        check("R4 req addr", last_addr, 32'h4000_0100);
        check("R4 req be/wr", {27'd0, last_wr, last_be}, 32'h0F);
        idle(10);
        txn(4'b0110, 32'h4000_0100, 4'hF, '0);
        check("R7 trdy on match", {30'd0, s_trdy, s_stop}, 32'd2);
        check("R7 oe", {31'd0, s_oe}, 32'd1);
        check("R7 read data", s_ad, 32'h4000_0100 ^ KEY);
        check("R7 single cycle", {30'd0, trdy_o, stop_o}, 32'd0);
    endtask

    task automatic t_other_while_busy;
        int n0 = n_req;
        txn(4'b0010, 32'h4000_0200, 4'h3, '0);
        idle(10);
        txn(4'b0110, 32'h4000_0300, 4'hF, '0);
        check("R5 other retried", {30'd0, s_trdy, s_stop}, 32'd1);
        idle(6);
        check("R5 other not recorded", n_req, n0 + 1);
        txn(4'b0010, 32'h4000_0200, 4'h3, '0);
        check("R5 original delivered", {30'd0, s_trdy, s_stop}, 32'd2);
        check("R5 original data", s_ad, 32'h4000_0200 ^ KEY);
    endtask

    task automatic t_fields;
        int n0 = n_req;
        txn(4'b0110, 32'h4000_0400, 4'hF, '0);
        idle(10);
        txn(4'b0110, 32'h4000_0400, 4'h3, '0);
        check("R8 be mismatch retried", {30'd0, s_trdy, s_stop}, 32'd1);
        txn(4'b0110, 32'h4000_0400, 4'hF, '0);
        check("R8 exact be delivered", {30'd0, s_trdy, s_stop}, 32'd2);
        txn(4'b0011, 32'h4000_0404, 4'h6, 32'hCAFE_0001);
        check("R4 write stop", {30'd0, s_trdy, s_stop}, 32'd1);
        idle(10);
        check("R4 write req fields", {27'd0, last_wr, last_be}, 32'h16);
        check("R4 write data", last_wdata, 32'hCAFE_0001);
        txn(4'b0011, 32'h4000_0404, 4'h6, 32'hCAFE_0002);
        check("R8 data mismatch retried", {30'd0, s_trdy, s_stop}, 32'd1);
        txn(4'b0011, 32'h4000_0404, 4'h6, 32'hCAFE_0001);
        check("R8 write match trdy", {30'd0, s_trdy, s_stop}, 32'd2);
        check("R8 write no oe", {31'd0, s_oe}, 32'd0);
        check("R8 backend count", n_req, n0 + 2);
    endtask

    task automatic t_free_after_delivery;
        int n0;
        txn(4'b0110, 32'h4000_0500, 4'hF, '0);
        idle(10);
        txn(4'b0110, 32'h4000_0500, 4'hF, '0);
        check("R9 delivered", {30'd0, s_trdy, s_stop}, 32'd2);
        n0 = n_req;
        txn(4'b0110, 32'h4000_0500, 4'hF, '0);
        check("R9 repeat recorded anew", {30'd0, s_trdy, s_stop}, 32'd1);
        idle(6);
        check("R9 new backend req", n_req, n0 + 1);
        idle(4);
        txn(4'b0110, 32'h4000_0500, 4'hF, '0);
        check("R9 second delivery", {30'd0, s_trdy, s_stop}, 32'd2);
    endtask

    task automatic t_discard;
        int n0;
        txn(4'b0110, 32'h4000_0600, 4'hF, '0);
        idle(10 + (1 << DISCARD_W) + 20);
        n0 = n_req;
        txn(4'b0110, 32'h4000_0600, 4'hF, '0);
        check("R10 discarded then retried", {30'd0, s_trdy, s_stop}, 32'd1);
        idle(6);
        check("R10 recorded again", n_req, n0 + 1);
        idle(4);
        txn(4'b0110, 32'h4000_0600, 4'hF, '0);
        check("R10 fresh delivery", s_ad, 32'h4000_0600 ^ KEY);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_miss();
        t_basic_read();
        t_other_while_busy();
        t_fields();
        t_free_after_delivery();
        t_discard();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule